// File: doc/BRIEF.md
# Page Write Buffer Sequencer

This block sits between a serial-memory protocol engine and a byte-wide storage array. The engine first hands it a byte address, then a stream of data bytes. The block latches them into a sixteen-entry page buffer. Only the low four address bits advance from byte to byte, so a long stream wraps around inside one page instead of spilling into the next one. Each byte comes with a protect flag. A byte that arrives with its protect flag set is dropped and does not move the offset.

Nothing reaches the array until the engine reports a STOP that fell in the slot right after an acknowledge. That event starts the commit:

- **ST_COMMIT** walks the sixteen buffer entries, one per cycle, and writes every entry that holds a byte.
- **ST_PROGRAM** then runs a down-counter that stands in for the self-timed programming cycle.

The `busy` flag is high for the whole of both states. While it is high, every command input is ignored, so the engine does not respond on the bus. A STOP reported at any other bit position abandons the buffered bytes. The array comes out of reset with every location reading FFh.

The FSM has four states:

- **ST_IDLE**: waiting for an address.
- **ST_COLLECT**: latching bytes.
- **ST_COMMIT**: writing the buffer to the array.
- **ST_PROGRAM**: timed busy period.

Its transitions are:

- **T_LOAD**: IDLE to COLLECT on an address load.
- **T_RELOAD**: COLLECT to COLLECT on a new address load. The buffer is cleared.
- **T_ABORT**: COLLECT to IDLE on a misplaced STOP.
- **T_QUALIFY**: COLLECT to COMMIT on a STOP after an acknowledge.
- **T_STEP**: COMMIT to COMMIT while the entry index is below 15.
- **T_ARM**: COMMIT to PROGRAM after entry 15. This loads the timer.
- **T_EXPIRE**: PROGRAM to IDLE when the timer reaches zero.

Top module: `pgwr_seq`

## Requirements
- R1: After reset `busy` is 0 and every array location reads FFh.
- R2: An address load sets the page (address bits 7:4) and the in-page offset (bits 3:0). Accepted bytes fill consecutive offsets. A second load before the commit clears all bytes buffered so far.
- R3: Only the 4-bit offset increments, modulo 16, so a page boundary is never crossed. When more than 16 bytes are sent, the last byte written to each offset is the one stored.
- R4: A `stop_at_ack` pulse in ST_COLLECT starts a commit, even when no bytes are buffered. A `stop_abort` pulse in ST_COLLECT discards the buffer, and `busy` stays 0. If both arrive in the same cycle, `stop_abort` wins.
- R5: A byte strobed with `byte_wp`=1 is neither stored nor counted, so the offset does not advance.
- R6: `busy` rises in the cycle after the edge that samples `stop_at_ack`. It stays high for exactly PAGE_BYTES+BUSY_CYCLES cycles (16+24 = 40 by default).
- R7: While `busy` is 1, address loads, byte strobes and both STOP inputs have no effect.
- R8: Array writes (`mem_we`=1) happen only while `busy` is 1, and every write address lies in the loaded page.
- R9: The read port returns `rd_data` one clock after `rd_addr` is applied. After `busy` falls, committed bytes are readable and every other location keeps its earlier value.
- R10: In ST_IDLE, byte strobes and STOP inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load the start address |
| addr_in | input | ADDR_W | Start byte address |
| byte_stb | input | 1 | One data byte is presented |
| byte_data | input | DATA_W | Data byte |
| byte_wp | input | 1 | Byte was refused (write protect) |
| stop_at_ack | input | 1 | STOP seen in the slot after an acknowledge |
| stop_abort | input | 1 | STOP seen at any other bit position |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit or programming cycle in progress |

## Verification
Each command input is driven on a falling edge and takes effect at the next rising edge. After a `stop_at_ack` pulse, the bench expects `busy` at the very next falling edge. From there it counts falling edges until `busy` drops and requires 40 of them. The commit writes appear during the first 16 of those cycles, and the bench checks their page as they occur. Reads present the address on one falling edge and compare `rd_data` on the next, which matches the one register on the read path. The bench compares memory only after `busy` has fallen, and it checks ignored stimulus by reading back the pages that stimulus would have touched.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_PROGRAM = 2'd3
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_latch.sv
// Page buffer: one data register and one valid flag per in-page offset.
module pgwr_latch #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] ent_data  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] ent_valid;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
        logic hit;
        assign hit = wr_en && (wr_idx == OFF_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid[g] <= 1'b0;
            end else if (clr) begin
                ent_valid[g] <= 1'b0;
            end else if (hit) begin
                ent_valid[g] <= 1'b1;
            end
        end

        // A later byte to the same offset overwrites the earlier one.
        always_ff @(posedge clk) begin
            if (hit) begin
                ent_data[g] <= wr_data;
            end
        end
    end

    assign rd_data  = ent_data[rd_idx];
    assign rd_valid = ent_valid[rd_idx];
endmodule

// File: rtl/pgwr_timer.sv
// Down-counter standing in for the self-timed programming interval.
module pgwr_timer #(
    parameter int BUSY_CYCLES = 24,
    localparam int TMR_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= TMR_W'(BUSY_CYCLES - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - TMR_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pgwr_array.sv
// Storage array: one synchronous write port, one registered read port,
// every location reset to all ones.
module pgwr_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '1;
        end else begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/pgwr_seq.sv
// Page write sequencer: collect bytes, commit the page on a qualified STOP,
// then hold busy for the programming interval.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_wp,
    input  logic              stop_at_ack,
    input  logic              stop_abort,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(PAGE_BYTES - 1);

    pgwr_state_e state_q, state_d;

    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  idx_q;
    logic              busy_q;

    logic              in_collect;
    logic              take_abort;
    logic              take_commit;
    logic              take_load;
    logic              take_byte;
    logic              tmr_start;
    logic              tmr_expired;
    logic [DATA_W-1:0] ent_data;
    logic              ent_valid;

    // Command decode, in priority order:
    // misplaced STOP, qualified STOP, address load, byte.
    assign in_collect  = (state_q == ST_COLLECT);
    assign take_abort  = in_collect && stop_abort;
    assign take_commit = in_collect && stop_at_ack && !stop_abort;
    assign take_load   = addr_ld && !take_abort && !take_commit
                       && ((state_q == ST_IDLE) || in_collect);
    assign take_byte   = in_collect && byte_stb && !byte_wp
                       && !stop_abort && !stop_at_ack && !addr_ld;
    assign tmr_start   = (state_q == ST_COMMIT) && (idx_q == LAST_IDX);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_load) state_d = ST_COLLECT;          // T_LOAD
            end
            ST_COLLECT: begin
                if (take_abort)       state_d = ST_IDLE;      // T_ABORT
                else if (take_commit) state_d = ST_COMMIT;    // T_QUALIFY
                else                  state_d = ST_COLLECT;   // T_RELOAD or byte
            end
            ST_COMMIT: begin
                if (idx_q == LAST_IDX) state_d = ST_PROGRAM;  // T_ARM
                else                   state_d = ST_COMMIT;   // T_STEP
            end
            ST_PROGRAM: begin
                if (tmr_expired) state_d = ST_IDLE;           // T_EXPIRE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= (state_d == ST_COMMIT) || (state_d == ST_PROGRAM);
            if (take_load) begin
                page_q <= addr_in[ADDR_W-1:OFF_W];
                off_q  <= addr_in[OFF_W-1:0];
            end else if (take_byte) begin
                off_q  <= off_q + OFF_W'(1);   // wraps inside the page
            end
            if (take_commit) begin
                idx_q <= '0;
            end else if (state_q == ST_COMMIT) begin
                idx_q <= idx_q + OFF_W'(1);
            end
        end
    end

    pgwr_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (take_load),
        .wr_en    (take_byte),
        .wr_idx   (off_q),
        .wr_data  (byte_data),
        .rd_idx   (idx_q),
        .rd_data  (ent_data),
        .rd_valid (ent_valid)
    );

    pgwr_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (state_q == ST_PROGRAM),
        .expired (tmr_expired)
    );

    // Array write port, driven from the commit walk
    assign mem_we    = (state_q == ST_COMMIT) && ent_valid;
    assign mem_waddr = {page_q, idx_q};
    assign mem_wdata = ent_data;
    assign busy      = busy_q;

    pgwr_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_at_ack,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int TOTAL = PAGE_BYTES + BUSY_CYCLES;

    int busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    always_comb begin
        if (!rst_n) a_r1_reset_idle: assert (!busy);
    end

    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == TOTAL));

    a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < TOTAL));

    a_r4_qualified_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_at_ack));

    a_r8_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r3_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
        (mem_waddr[ADDR_W-1:OFF_W] == $past(mem_waddr[ADDR_W-1:OFF_W])));
endmodule

bind pgwr_seq pgwr_seq_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_at_ack (stop_at_ack),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr)
);

// File: tb/pgwr_seq_tb.sv
`timescale 1ns/1ps
module pgwr_seq_tb;
    localparam int TOTAL = 16 + 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_ld = 1'b0;
    logic [7:0] addr_in = '0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_wp = 1'b0;
    logic       stop_at_ack = 1'b0;
    logic       stop_abort = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       mem_we;
    logic [7:0] mem_waddr;
    logic [7:0] mem_wdata;
    logic       busy;

    always #5 clk = ~clk;

    pgwr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_data(byte_data), .byte_wp(byte_wp),
        .stop_at_ack(stop_at_ack), .stop_abort(stop_abort),
        .rd_addr(rd_addr), .rd_data(rd_data), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .busy(busy)
    );

    int tests = 0;
    int fails = 0;

    // Bench model of the array and of the pending page
    logic [7:0] model [256];
    logic [7:0] pend_d [16];
    logic       pend_v [16];
    int         cur_pg = 0;
    int         cur_off = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input int a);
        @(negedge clk); addr_ld = 1'b1; addr_in = 8'(a);
        @(negedge clk); addr_ld = 1'b0;
        cur_pg = a >> 4; cur_off = a & 15;
        for (int i = 0; i < 16; i++) pend_v[i] = 1'b0;
    endtask

    task automatic send(input int d, input bit wp);
        @(negedge clk); byte_stb = 1'b1; byte_data = 8'(d); byte_wp = wp;
        @(negedge clk); byte_stb = 1'b0; byte_wp = 1'b0;
        if (!wp) begin
            pend_d[cur_off] = 8'(d); pend_v[cur_off] = 1'b1;
            cur_off = (cur_off + 1) % 16;
        end
    endtask

    task automatic apply_pending();
        for (int i = 0; i < 16; i++)
            if (pend_v[i]) model[cur_pg*16 + i] = pend_d[i];
        for (int i = 0; i < 16; i++) pend_v[i] = 1'b0;
    endtask

    task automatic commit();
        int cnt;
        @(negedge clk); stop_at_ack = 1'b1;
        @(negedge clk); stop_at_ack = 1'b0;
        check(busy == 1'b1, "R6 busy rise", int'(busy), 1);
        cnt = 0;
        while (busy && cnt < 1000) begin
            if (mem_we)   // R8: writes stay in the loaded page
                check(int'(mem_waddr >> 4) == cur_pg, "R8 write page", int'(mem_waddr >> 4), cur_pg);
            cnt++;
            @(negedge clk);
        end
        check(cnt == TOTAL, "R6 busy length", cnt, TOTAL);
        apply_pending();
    endtask

    task automatic read_chk(input int a, input string req);
        @(negedge clk); rd_addr = 8'(a);
        @(negedge clk);
        check(rd_data == model[a], req, int'(rd_data), int'(model[a]));
    endtask

    task automatic page_chk(input int pg, input string req);
        for (int i = 0; i < 16; i++) read_chk(pg*16 + i, req);
    endtask

    task automatic quiet_chk(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(busy == 1'b0, req, int'(busy), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        for (int i = 0; i < 16; i++) begin pend_v[i] = 1'b0; pend_d[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        for (int a = 0; a < 256; a++) read_chk(a, "R1 reset FFh");

        // R2, R9: single byte
        load(8'h20); send(8'h5A, 1'b0); commit();
        page_chk(2, "R9 single byte readback");

        // R2, R5: sweep every page, start offset and length
        for (int k = 0; k < 16; k++) begin
            load(k*16 + ((k*5) & 15));
            for (int i = 0; i <= k; i++)
                send((k*37 + i*11 + 3) & 255, (k % 4 == 3) && (i == 1));
            commit();
            page_chk(k, "R2 R5 sweep readback");
        end

        // R3: 20 bytes from offset 14 wrap inside page 3, last write wins
        load(8'h3E);
        for (int i = 0; i < 20; i++) send(8'hA0 + i, 1'b0);
        commit();
        page_chk(3, "R3 wrap readback");
        page_chk(4, "R3 neighbour page untouched");

        // R4: misplaced STOP discards
        load(8'h50); send(8'h11, 1'b0); send(8'h22, 1'b0);
        @(negedge clk); stop_abort = 1'b1;
        @(negedge clk); stop_abort = 1'b0;
        for (int i = 0; i < 16; i++) pend_v[i] = 1'b0;
        quiet_chk(3, "R4 abort no busy");
        page_chk(5, "R4 abort no write");

        // R4: both STOPs together, abort wins
        load(8'h51); send(8'h33, 1'b0);
        @(negedge clk); stop_abort = 1'b1; stop_at_ack = 1'b1;
        @(negedge clk); stop_abort = 1'b0; stop_at_ack = 1'b0;
        for (int i = 0; i < 16; i++) pend_v[i] = 1'b0;
        quiet_chk(3, "R4 abort priority");
        page_chk(5, "R4 abort priority no write");

        // R4: commit with no bytes still runs a full cycle
        load(8'h90); commit();
        page_chk(9, "R4 empty commit no write");

        // R2: reload clears earlier bytes
        load(8'h60); send(8'h77, 1'b0); send(8'h78, 1'b0);
        load(8'h68); send(8'h79, 1'b0); commit();
        page_chk(6, "R2 reload");

        // R7: command inputs during busy are ignored
        load(8'h70); send(8'hC1, 1'b0); send(8'hC2, 1'b0);
        @(negedge clk); stop_at_ack = 1'b1;
        @(negedge clk); stop_at_ack = 1'b0;
        check(busy == 1'b1, "R7 busy entered", int'(busy), 1);
        apply_pending();
        repeat (2) @(negedge clk);
        @(negedge clk); addr_ld = 1'b1; addr_in = 8'h80;
        @(negedge clk); addr_ld = 1'b0; byte_stb = 1'b1; byte_data = 8'hEE;
        @(negedge clk); byte_stb = 1'b0; stop_at_ack = 1'b1;
        @(negedge clk); stop_at_ack = 1'b0;
        for (int n = 0; n < 200 && busy; n++) @(negedge clk);
        quiet_chk(4, "R7 no second cycle");
        page_chk(7, "R7 page 7 committed");
        page_chk(8, "R7 page 8 untouched");

        // R10: idle ignores bytes and STOPs
        send(8'h44, 1'b0);
        for (int i = 0; i < 16; i++) pend_v[i] = 1'b0;
        @(negedge clk); stop_at_ack = 1'b1;
        @(negedge clk); stop_at_ack = 1'b0; stop_abort = 1'b1;
        @(negedge clk); stop_abort = 1'b0;
        quiet_chk(3, "R10 idle stop ignored");

        // R9: full array compare
        for (int a = 0; a < 256; a++) read_chk(a, "R9 final array");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule